// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block is a free-running hardware clock for precision time protocols. A 64-bit whole-nanosecond word and a 32-bit sub-nanosecond fraction together form one accumulator. While the clock is enabled, a programmable increment in 32.32 fixed point (upper 32 bits whole nanoseconds, lower 32 bits fraction) is added to it on every core clock cycle. The nominal increment is 10^9·2^32 divided by the core clock rate in Hz. For an 800 MHz core this is 1.25 ns, or 0x0000_0001_4000_0000.

Software controls the clock through a small 64-bit register port with four registers: control, increment, fraction and whole nanoseconds. Frequency trim is done only by rewriting the increment. The new value applies from the next cycle and does not disturb the accumulated time. Reads return one cycle after the request. A fraction read captures the whole word at the same instant, so that a following whole read returns a coherent pair.

Top module: `frac_tod_counter`

## Requirements
- R1: After reset the enable bit is 0, both time words read 0 and the increment reads the nominal value (0x0000_0001_4000_0000 with the default parameters).
- R2: In every cycle where enable is 1 and no time word is written, the 96-bit value {whole, fraction} grows by the increment taken as a zero-extended 32.32 value. A carry out of the fraction enters the whole word in that same cycle.
- R3: While enable is 0, both time words keep their values.
- R4: The register offsets from the base address are 0x00 control (bit 0 = enable, other bits read 0 and are ignored on write), 0x08 increment, 0x10 fraction (bits 31:0; bits 63:32 read 0 and are ignored on write) and 0x18 whole nanoseconds. Any other address reads 0.
- R5: A new increment written in cycle t is first used in cycle t+1, and the time already accumulated is not altered by the write.
- R6: A write to a time word replaces that word, whether or not the clock is enabled. In that cycle the accumulator does not advance and the other time word holds.
- R7: A read request in cycle t gives read-valid and data in cycle t+1. The data reflect the register contents in cycle t, before any write made in that same cycle.
- R8: A fraction read also copies the whole word into a shadow. The next whole read returns the shadow and consumes it. A whole read with no pending shadow returns the live count.
- R9: Read-valid is low in every cycle that follows a cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; the accumulator advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address, shared by reads and writes |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | REG_W (64) | Write data |
| bus_rd | input | 1 | Read request for one cycle |
| bus_rdata | output | REG_W (64) | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The accumulator runs with the reset-nominal increment (fraction 0.25, a carry every fourth cycle) and with an all-ones fraction increment that carries on nearly every cycle. These two cases test the carry path in both directions. Over about 100,000 cycles, pseudo-random increments replace each other mid-run. Each replacement separates a value that takes effect in the correct cycle from one that is early, late, or disturbs the time already accumulated. Reads alternate between fraction, shadowed whole and live whole, so a stale or missing shadow shows up as a different value from the live count. Time-word writes issued while the clock is enabled, writes to the masked bits, and a disabled interval test write priority, field masking and the hold.

// File: rtl/frac_tod_pkg.sv
package frac_tod_pkg;

   // Register selected by the decoder; the index times the stride is the offset.
   typedef enum logic [2:0] {
      REG_CTRL  = 3'd0,
      REG_INCR  = 3'd1,
      REG_FRAC  = 3'd2,
      REG_WHOLE = 3'd3,
      REG_NONE  = 3'd4
   } tod_reg_e;

   localparam int unsigned NUM_REGS   = 4;
   localparam int unsigned REG_STRIDE = 8;

endpackage

// File: rtl/frac_tod_decode.sv
module frac_tod_decode
   import frac_tod_pkg::*;
#(
   parameter int unsigned           ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]     BASE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output tod_reg_e          sel_o
);

   logic [NUM_REGS-1:0] hit;

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
      assign hit[k] = (addr_i == BASE_ADDR + ADDR_W'(k * REG_STRIDE));
   end

   always_comb begin
      sel_o = REG_NONE;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (hit[k]) sel_o = tod_reg_e'(3'(k));
      end
   end

endmodule

// File: rtl/frac_tod_accum.sv
module frac_tod_accum #(
   parameter int unsigned WHOLE_W   = 64,
   parameter int unsigned FRAC_W    = 32,
   parameter int unsigned INT_W     = 32,
   parameter bit          SPLIT_ADD = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      advance_i,
   input  logic [INT_W+FRAC_W-1:0]   incr_i,
   input  logic                      ld_frac_i,
   input  logic [FRAC_W-1:0]         ld_frac_val_i,
   input  logic                      ld_whole_i,
   input  logic [WHOLE_W-1:0]        ld_whole_val_i,
   output logic [WHOLE_W-1:0]        whole_o,
   output logic [FRAC_W-1:0]         frac_o
);

   localparam int unsigned INCR_W = INT_W + FRAC_W;
   localparam int unsigned ACC_W  = WHOLE_W + FRAC_W;

   if (INT_W > WHOLE_W) begin : g_bad_int
      $error("increment integer part wider than whole-nanosecond word");
   end

   logic [WHOLE_W-1:0] whole_q, whole_nx;
   logic [FRAC_W-1:0]  frac_q,  frac_nx;

   if (SPLIT_ADD) begin : g_split
      // Fraction adder first; its carry feeds the whole-word adder.
      logic [FRAC_W:0] fsum;
      assign fsum     = {1'b0, frac_q} + {1'b0, incr_i[FRAC_W-1:0]};
      assign frac_nx  = fsum[FRAC_W-1:0];
      assign whole_nx = whole_q + WHOLE_W'(incr_i[INCR_W-1:FRAC_W])
                        + WHOLE_W'(fsum[FRAC_W]);
   end else begin : g_wide
      logic [ACC_W-1:0] sum;
      assign sum                 = {whole_q, frac_q} + ACC_W'(incr_i);
      assign {whole_nx, frac_nx} = sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         whole_q <= '0;
         frac_q  <= '0;
      end else if (ld_frac_i || ld_whole_i) begin
         if (ld_frac_i)  frac_q  <= ld_frac_val_i;
         if (ld_whole_i) whole_q <= ld_whole_val_i;
      end else if (advance_i) begin
         whole_q <= whole_nx;
         frac_q  <= frac_nx;
      end
   end

   assign whole_o = whole_q;
   assign frac_o  = frac_q;

endmodule

// File: rtl/frac_tod_rdport.sv
module frac_tod_rdport
   import frac_tod_pkg::*;
#(
   parameter int unsigned REG_W   = 64,
   parameter int unsigned WHOLE_W = 64,
   parameter int unsigned FRAC_W  = 32,
   parameter int unsigned INCR_W  = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_i,
   input  tod_reg_e            sel_i,
   input  logic                enable_i,
   input  logic [INCR_W-1:0]   incr_i,
   input  logic [FRAC_W-1:0]   frac_i,
   input  logic [WHOLE_W-1:0]  whole_i,
   output logic [REG_W-1:0]    rdata_o,
   output logic                rvalid_o
);

   logic [WHOLE_W-1:0] shadow_q;
   logic               shadow_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o      <= '0;
         rvalid_o     <= 1'b0;
         shadow_q     <= '0;
         shadow_vld_q <= 1'b0;
      end else begin
         rvalid_o <= rd_i;
         if (rd_i) begin
            case (sel_i)
               REG_CTRL:  rdata_o <= REG_W'(enable_i);
               REG_INCR:  rdata_o <= REG_W'(incr_i);
               REG_FRAC: begin
                  rdata_o      <= REG_W'(frac_i);
                  shadow_q     <= whole_i;
                  shadow_vld_q <= 1'b1;
               end
               REG_WHOLE: begin
                  rdata_o      <= shadow_vld_q ? REG_W'(shadow_q) : REG_W'(whole_i);
                  shadow_vld_q <= 1'b0;
               end
               default:   rdata_o <= '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/frac_tod_counter.sv
module frac_tod_counter
   import frac_tod_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 12,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100,
   parameter int unsigned       REG_W     = 64,
   parameter int unsigned       WHOLE_W   = 64,
   parameter int unsigned       FRAC_W    = 32,
   parameter int unsigned       INT_W     = 32,
   parameter longint unsigned   CORE_HZ   = 800_000_000,
   parameter bit                SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [REG_W-1:0]  bus_rdata,
   output logic              bus_rvalid
);

   localparam int unsigned INCR_W = INT_W + FRAC_W;
   localparam logic [63:0] NOMINAL =
      (64'd1_000_000_000 << FRAC_W) / 64'(CORE_HZ);
   localparam logic [INCR_W-1:0] INCR_RESET = INCR_W'(NOMINAL);

   if (REG_W < INCR_W || REG_W < WHOLE_W || REG_W < FRAC_W) begin : g_bad_reg_w
      $error("register width too narrow for a field");
   end
   if (FRAC_W < 1 || FRAC_W > 32) begin : g_bad_frac_w
      $error("fraction width must be 1..32");
   end
   if (CORE_HZ == 0) begin : g_bad_hz
      $error("core clock rate must be non-zero");
   end
   if (BASE_ADDR[2:0] != 3'b000 || ADDR_W < 5) begin : g_bad_base
      $error("base address must be 8-byte aligned with room for four registers");
   end

   tod_reg_e           sel;
   logic               en_q;
   logic [INCR_W-1:0]  incr_q;
   logic               ld_frac, ld_whole;
   logic [WHOLE_W-1:0] whole;
   logic [FRAC_W-1:0]  frac;

   frac_tod_decode #(
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_decode (
      .addr_i(bus_addr),
      .sel_o (sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         incr_q <= INCR_RESET;
      end else if (bus_wr) begin
         if (sel == REG_CTRL) en_q   <= bus_wdata[0];
         if (sel == REG_INCR) incr_q <= bus_wdata[INCR_W-1:0];
      end
   end

   assign ld_frac  = bus_wr && (sel == REG_FRAC);
   assign ld_whole = bus_wr && (sel == REG_WHOLE);

   frac_tod_accum #(
      .WHOLE_W  (WHOLE_W),
      .FRAC_W   (FRAC_W),
      .INT_W    (INT_W),
      .SPLIT_ADD(SPLIT_ADD)
   ) u_accum (
      .clk           (clk),
      .rst_n         (rst_n),
      .advance_i     (en_q),
      .incr_i        (incr_q),
      .ld_frac_i     (ld_frac),
      .ld_frac_val_i (bus_wdata[FRAC_W-1:0]),
      .ld_whole_i    (ld_whole),
      .ld_whole_val_i(bus_wdata[WHOLE_W-1:0]),
      .whole_o       (whole),
      .frac_o        (frac)
   );

   frac_tod_rdport #(
      .REG_W  (REG_W),
      .WHOLE_W(WHOLE_W),
      .FRAC_W (FRAC_W),
      .INCR_W (INCR_W)
   ) u_rdport (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (bus_rd),
      .sel_i   (sel),
      .enable_i(en_q),
      .incr_i  (incr_q),
      .frac_i  (frac),
      .whole_i (whole),
      .rdata_o (bus_rdata),
      .rvalid_o(bus_rvalid)
   );

endmodule

// File: rtl/frac_tod_counter_chk.sv
module frac_tod_counter_chk #(
   parameter int unsigned WHOLE_W = 64,
   parameter int unsigned FRAC_W  = 32,
   parameter int unsigned INCR_W  = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd,
   input logic               rvalid,
   input logic               en,
   input logic               ld_frac,
   input logic               ld_whole,
   input logic [WHOLE_W-1:0] ld_whole_val,
   input logic [INCR_W-1:0]  incr,
   input logic [WHOLE_W-1:0] whole,
   input logic [FRAC_W-1:0]  frac
);

   localparam int unsigned ACC_W = WHOLE_W + FRAC_W;

   logic [ACC_W-1:0] acc;
   logic             twr;
   assign acc = {whole, frac};
   assign twr = ld_frac || ld_whole;

   p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en && !twr |=> (acc - $past(acc)) == ACC_W'($past(incr)));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !twr |=> $stable(acc));

   p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_whole |=> whole == $past(ld_whole_val));

   p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> rvalid);

   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> !rvalid);

endmodule

bind frac_tod_counter frac_tod_counter_chk #(
   .WHOLE_W(WHOLE_W),
   .FRAC_W (FRAC_W),
   .INCR_W (INCR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd          (bus_rd),
   .rvalid      (bus_rvalid),
   .en          (en_q),
   .ld_frac     (ld_frac),
   .ld_whole    (ld_whole),
   .ld_whole_val(bus_wdata[WHOLE_W-1:0]),
   .incr        (incr_q),
   .whole       (whole),
   .frac        (frac)
);

// File: tb/frac_tod_counter_tb.sv
`timescale 1ns/1ps
module frac_tod_counter_tb_top;

   localparam logic [11:0] A_CTRL  = 12'h100;
   localparam logic [11:0] A_INCR  = 12'h108;
   localparam logic [11:0] A_FRAC  = 12'h110;
   localparam logic [11:0] A_WHOLE = 12'h118;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [63:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [63:0] bus_rdata;
   logic        bus_rvalid;

   always #10 clk = ~clk;

   frac_tod_counter dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .bus_rvalid(bus_rvalid)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   string phase    = "R1 reset state";

   // Behavioural reference: 128-bit time, modelled from the requirements.
   bit          m_en;
   bit [63:0]   m_incr, m_whole, m_shadow, exp_d;
   bit [31:0]   m_frac;
   bit          m_shv, exp_v;
   bit [127:0]  m_acc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_incr = 64'h0000_0001_4000_0000;
         m_whole = 0; m_frac = 0; m_shadow = 0; m_shv = 0;
         exp_v = 0; exp_d = 0;
      end else begin
         exp_v = bus_rd;
         if (bus_rd) begin
            case (bus_addr)
               A_CTRL:  exp_d = {63'b0, m_en};
               A_INCR:  exp_d = m_incr;
               A_FRAC:  begin exp_d = {32'b0, m_frac}; m_shadow = m_whole; m_shv = 1; end
               A_WHOLE: begin exp_d = m_shv ? m_shadow : m_whole; m_shv = 0; end
               default: exp_d = 0;
            endcase
         end
         if (bus_wr && (bus_addr == A_FRAC || bus_addr == A_WHOLE)) begin
            if (bus_addr == A_FRAC)  m_frac  = bus_wdata[31:0];
            if (bus_addr == A_WHOLE) m_whole = bus_wdata;
         end else if (m_en) begin
            m_acc = {32'b0, m_whole, m_frac} + {64'b0, m_incr};
            {m_whole, m_frac} = m_acc[95:0];
         end
         if (bus_wr && bus_addr == A_CTRL) m_en   = bus_wdata[0];
         if (bus_wr && bus_addr == A_INCR) m_incr = bus_wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_checks++;
         if (bus_rvalid !== exp_v) begin
            n_fail++;
            $display("FAIL R7/R9 read strobe: actual %b expected %b", bus_rvalid, exp_v);
         end
         if (exp_v) begin
            n_checks++;
            if (bus_rdata !== exp_d) begin
               n_fail++;
               $display("FAIL %s: actual %h expected %h", phase, bus_rdata, exp_d);
            end
         end
      end
   end

   task automatic do_rd(input logic [11:0] a);
      bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic do_wr(input logic [11:0] a, input logic [63:0] d);
      bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(20.0 * 190000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [63:0] seed = 64'h0123_4567_89AB_CDEF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values through the register port
      do_rd(A_CTRL); do_rd(A_INCR); do_rd(A_FRAC); do_rd(A_WHOLE);
      // R3: disabled clock holds
      phase = "R3 hold while disabled";
      idle(5); do_rd(A_FRAC); do_rd(A_WHOLE);
      // R2: nominal increment, carry every fourth cycle
      phase = "R2 accumulate nominal";
      do_wr(A_CTRL, 64'h1);
      for (int i = 0; i < 600; i++) do_rd((i % 2 == 0) ? A_FRAC : A_WHOLE);
      phase = "R2 accumulate dense carry";
      do_wr(A_INCR, 64'h0000_0000_FFFF_FFFF);
      for (int i = 0; i < 600; i++) do_rd((i % 2 == 0) ? A_FRAC : A_WHOLE);
      // R5: mid-run increment changes with a long stream
      phase = "R5 increment rewrite";
      for (int i = 0; i < 100000; i++) begin
         if (i % 4999 == 0) begin
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            do_wr(A_INCR, {28'b0, seed[63:60], seed[31:0]});
            do_rd(A_INCR);
         end else begin
            case (i % 3)
               0:       do_rd(A_FRAC);
               1:       do_rd(A_WHOLE);
               default: do_rd(A_WHOLE);
            endcase
         end
      end
      // R6: time writes while enabled, incl. frac near wrap
      phase = "R6 time word write";
      do_wr(A_WHOLE, 64'h0000_1234_0000_0000);
      do_rd(A_WHOLE);
      do_wr(A_FRAC, 64'hDEAD_BEEF_FFFF_FFF0);
      do_rd(A_FRAC); do_rd(A_WHOLE);
      do_wr(A_WHOLE, 64'hFFFF_FFFF_FFFF_FFFF);
      do_rd(A_FRAC); do_rd(A_WHOLE); idle(3); do_rd(A_WHOLE);
      // R8: shadow pairing versus live value
      phase = "R8 coherent pair";
      do_rd(A_FRAC); idle(7); do_rd(A_WHOLE); idle(2); do_rd(A_WHOLE);
      do_rd(A_FRAC); do_rd(A_FRAC); idle(3); do_rd(A_WHOLE);
      // R4: map, masked bits, unmapped addresses
      phase = "R4 register map";
      do_rd(12'h120); do_rd(12'h104); do_rd(12'h0F8);
      do_wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE);
      do_rd(A_CTRL);
      phase = "R3 hold after disable";
      do_rd(A_FRAC); idle(6); do_rd(A_FRAC); do_rd(A_WHOLE);
      do_wr(A_FRAC, 64'h0000_0000_0000_0042);
      do_rd(A_FRAC);
      phase = "R7 same-cycle write then read";
      do_wr(A_CTRL, 64'h1); do_rd(A_CTRL);
      phase = "R9 idle";
      idle(5);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule